// File: doc/BRIEF.md
# Bit-Serial Canonical Huffman Coefficient Decoder

This block turns a serial stream of entropy-coded bits into image coefficients. Every accepted bit is shifted into a candidate code. For each length from 1 to 16, the block looks up that length's lowest code, highest code and the position in the symbol list of the first symbol of that length. A candidate matches when it falls inside its length's code range. The symbol index is then the candidate minus the lowest code, plus that first position.

Each accepted bit gets a report: either the matched index or the sentinel 255, which asks for one more bit. A matched symbol gives a zero-run count and a magnitude category (size). For AC tables these are the upper and lower nibbles of the symbol. For DC tables the run is zero. The decoder then collects `size` amplitude bits and sign-extends them into a signed coefficient.

Four preset tables are held on chip and picked per code by a 2-bit selector. Fetching bits from the byte stream and scaling the coefficients are done elsewhere.

Top module: `hdc_coef_decoder`

## Requirements
- R1: After reset, `step_valid`, `sym_valid` and `coef_valid` are low, the decoder waits for the first bit of a code, and any partly collected code is discarded.
- R2: Each bit taken in the code phase (`bit_valid` high) raises `step_valid` exactly one cycle later. `step_idx` then holds the decoded symbol index on a match, or 255 when there is no match.
- R3: A candidate of length L matches when it lies between the lowest and highest code of length L. The index is the candidate minus the lowest code plus the first index of length L. `sym_value` is the list entry at that index, and `sym_valid` rises in the same cycle as `step_valid`.
- R4: The tables are canonical, with codes sent MSB first. The counts per length (L1..L16) are as follows. Luma DC: 0,1,5,1,1,1,1,1,1,0,0,0,0,0,0,0, with values 0..11 in order. Chroma DC: 0,3,1,1,1,1,1,1,1,1,1,0,0,0,0,0, with values 0..11. Luma AC: 0,2,1,3,3,2,4,1,0,0,0,0,0,0,0,2, with values 01,02,03,00,04,11,05,12,21,31,41,06,13,51,61,07,F0,A3 (hex). Chroma AC: 0,2,2,0,3,4,0,0,5,0,0,0,0,0,0,0, with values 00,01,02,11,03,04,21,12,31,41,05,51,13,61,22,0A (hex).
- R5: A length with no codes never matches, whatever the candidate.
- R6: For AC tables the run is `sym_value[7:4]` and the size is `sym_value[3:0]`. For DC tables the run is 0 and the size is `sym_value[3:0]`.
- R7: With size s>0, the amplitude bits A (MSB first) give A when A >= 2^(s-1), and A - 2^s + 1 otherwise. For example, s=2 with A=3 gives +3, and A=0 gives -3.
- R8: A symbol of size 0 yields `coef_valid` with value 0 in the same cycle as `sym_valid`, and takes no amplitude bits.
- R9: `tbl_sel` encodes 0 = luma DC, 1 = luma AC, 2 = chroma DC, 3 = chroma AC. It is sampled on the first bit of each code and held for the rest of that code and its amplitude.
- R10: If 16 bits gather without a match, the candidate is dropped after the sixteenth 255 report, and the next bit starts a new code.
- R11: While `bit_valid` is low, no state changes and all valid outputs stay low in the next cycle.
- R12: With size s>0, `coef_valid` rises one cycle after the s-th amplitude bit, carrying the symbol's run and size. No `step_valid` is raised for amplitude bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_sel | input | 2 | Table choice, sampled on the first bit of a code |
| bit_valid | input | 1 | A bit is presented this cycle |
| bit_in | input | 1 | Serial code or amplitude bit |
| step_valid | output | 1 | A code bit was consumed last cycle |
| step_idx | output | 8 | Matched index, or 255 for no match |
| sym_valid | output | 1 | A symbol was matched |
| sym_value | output | 8 | Matched symbol value |
| coef_valid | output | 1 | A coefficient is ready |
| coef_run | output | 4 | Zero run in front of the coefficient |
| coef_size | output | 4 | Magnitude category of the coefficient |
| coef_value | output | 16 | Signed coefficient |

## Verification
The case hardest to reach from the ports is a candidate passing through lengths that hold no codes. Close to it is a candidate that never matches within 16 bits. Both happen only when the stream steers the candidate into the long tail of the code space. The stimulus covers the long tail in three ways. It sends the two 16-bit luma AC codes, whose prefixes cross the empty lengths 9 to 15. It sends a run of sixteen ones, which no table accepts, followed by a valid code. It switches the table selector in the middle of a code. A vector table of worked amplitude cases and a stream of random symbols from all four tables check the split and sign extension against an encoder written in the bench.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int MAX_LEN   = 16;
  localparam int CODE_W    = 16;
  localparam int SYM_W     = 8;
  localparam int COEF_W    = 16;
  localparam int NUM_TBL   = 4;
  localparam int SYM_DEPTH = 32;
  localparam logic [SYM_W-1:0] NO_MATCH = 8'hFF;

  typedef enum logic {PH_CODE = 1'b0, PH_AMP = 1'b1} phase_e;

  typedef struct packed {
    logic [CODE_W-1:0] min_code;
    logic [CODE_W-1:0] max_code;
    logic [SYM_W-1:0]  first_idx;
    logic              empty;
  } len_entry_t;

  // number of codes of length l in table t
  function automatic logic [7:0] len_count(input logic [1:0] t, input int l);
    logic [7:0] n;
    n = 8'd0;
    case (t)
      2'd0: case (l)
              2: n = 8'd1;
              3: n = 8'd5;
              4, 5, 6, 7, 8, 9: n = 8'd1;
              default: n = 8'd0;
            endcase
      2'd1: case (l)
              2: n = 8'd2;
              3: n = 8'd1;
              4, 5: n = 8'd3;
              6: n = 8'd2;
              7: n = 8'd4;
              8: n = 8'd1;
              16: n = 8'd2;
              default: n = 8'd0;
            endcase
      2'd2: case (l)
              2: n = 8'd3;
              3, 4, 5, 6, 7, 8, 9, 10, 11: n = 8'd1;
              default: n = 8'd0;
            endcase
      default: case (l)
              2, 3: n = 8'd2;
              5: n = 8'd3;
              6: n = 8'd4;
              9: n = 8'd5;
              default: n = 8'd0;
            endcase
    endcase
    return n;
  endfunction

  // canonical range of one length, derived from the counts
  function automatic len_entry_t build_entry(input logic [1:0] t, input int l);
    len_entry_t      e;
    logic [CODE_W:0] code;
    logic [7:0]      first;
    logic [7:0]      n;
    e     = '0;
    code  = '0;
    first = '0;
    for (int i = 1; i <= MAX_LEN; i++) begin
      n = len_count(t, i);
      if (i == l) begin
        e.min_code  = code[CODE_W-1:0];
        e.max_code  = code[CODE_W-1:0] + CODE_W'(n) - CODE_W'(1);
        e.first_idx = first;
        e.empty     = (n == 8'd0);
      end
      code  = (code + (CODE_W+1)'(n)) << 1;
      first = first + n;
    end
    return e;
  endfunction

  // symbol list of table t, sorted by code length
  function automatic logic [SYM_W-1:0] sym_value(input logic [1:0] t, input int k);
    logic [SYM_W-1:0] v;
    v = 8'h00;
    if (t == 2'd0 || t == 2'd2) begin
      if (k < 12) v = SYM_W'(k);
    end else if (t == 2'd1) begin
      case (k)
        0: v = 8'h01;  1: v = 8'h02;  2: v = 8'h03;  3: v = 8'h00;
        4: v = 8'h04;  5: v = 8'h11;  6: v = 8'h05;  7: v = 8'h12;
        8: v = 8'h21;  9: v = 8'h31; 10: v = 8'h41; 11: v = 8'h06;
       12: v = 8'h13; 13: v = 8'h51; 14: v = 8'h61; 15: v = 8'h07;
       16: v = 8'hF0; 17: v = 8'hA3;
        default: v = 8'h00;
      endcase
    end else begin
      case (k)
        0: v = 8'h00;  1: v = 8'h01;  2: v = 8'h02;  3: v = 8'h11;
        4: v = 8'h03;  5: v = 8'h04;  6: v = 8'h21;  7: v = 8'h12;
        8: v = 8'h31;  9: v = 8'h41; 10: v = 8'h05; 11: v = 8'h51;
       12: v = 8'h13; 13: v = 8'h61; 14: v = 8'h22; 15: v = 8'h0A;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  // magnitude-category sign extension
  function automatic logic [COEF_W-1:0] extend_amp(input logic [COEF_W-1:0] bits,
                                                   input logic [3:0] size);
    logic [COEF_W:0]          thr;
    logic [COEF_W+1:0]        two_thr;
    logic signed [COEF_W+1:0] v;
    if (size == 4'd0) return '0;
    thr     = (COEF_W+1)'(1) << (size - 4'd1);
    two_thr = {thr, 1'b0};
    if ({1'b0, bits} >= thr) v = $signed({2'b00, bits});
    else v = $signed({2'b00, bits}) - $signed(two_thr) + (COEF_W+2)'(1);
    return v[COEF_W-1:0];
  endfunction
endpackage

// File: rtl/hdc_len_table.sv
module hdc_len_table
  import hdc_pkg::*;
#(
  parameter int N_TBL = NUM_TBL,
  parameter int N_LEN = MAX_LEN,
  localparam int TW = $clog2(N_TBL),
  localparam int LW = $clog2(N_LEN + 1)
) (
  input  logic [TW-1:0] tbl,
  input  logic [LW-1:0] len,
  output len_entry_t    entry
);
  len_entry_t rom [N_TBL][N_LEN];

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    for (genvar l = 0; l < N_LEN; l++) begin : g_len
      assign rom[t][l] = build_entry(2'(t), l + 1);
    end
  end

  always_comb begin
    entry       = '0;
    entry.empty = 1'b1;
    if (len != '0 && int'(len) <= N_LEN) entry = rom[tbl][len - LW'(1)];
  end
endmodule

// File: rtl/hdc_sym_rom.sv
module hdc_sym_rom
  import hdc_pkg::*;
#(
  parameter int N_TBL = NUM_TBL,
  parameter int DEPTH = SYM_DEPTH,
  localparam int TW = $clog2(N_TBL),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [TW-1:0]    tbl,
  input  logic [SYM_W-1:0] idx,
  output logic [SYM_W-1:0] value
);
  logic [SYM_W-1:0] rom [N_TBL][DEPTH];

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign rom[t][i] = sym_value(2'(t), i);
    end
  end

  always_comb begin
    value = '0;
    if (int'(idx) < DEPTH) value = rom[tbl][idx[AW-1:0]];
  end
endmodule

// File: rtl/hdc_matcher.sv
module hdc_matcher
  import hdc_pkg::*;
(
  input  len_entry_t       entry,
  input  logic [CODE_W-1:0] cand,
  output logic             hit,
  output logic [SYM_W-1:0] idx
);
  always_comb begin
    hit = !entry.empty && (cand >= entry.min_code) && (cand <= entry.max_code);
    idx = SYM_W'(cand - entry.min_code) + entry.first_idx;
  end
endmodule

// File: rtl/hdc_amp_extend.sv
module hdc_amp_extend
  import hdc_pkg::*;
(
  input  logic [COEF_W-1:0] bits,
  input  logic [3:0]        size,
  output logic [COEF_W-1:0] coef
);
  assign coef = extend_amp(bits, size);
endmodule

// File: rtl/hdc_coef_decoder.sv
module hdc_coef_decoder
  import hdc_pkg::*;
#(
  parameter int N_TBL = NUM_TBL,
  parameter int N_LEN = MAX_LEN,
  localparam int TW = $clog2(N_TBL),
  localparam int LW = $clog2(N_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tbl_sel,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              step_valid,
  output logic [7:0]        step_idx,
  output logic              sym_valid,
  output logic [7:0]        sym_value,
  output logic              coef_valid,
  output logic [3:0]        coef_run,
  output logic [3:0]        coef_size,
  output logic [15:0]       coef_value
);
  phase_e            phase_q;
  logic [CODE_W-1:0] cand_q;
  logic [LW-1:0]     len_q;
  logic [TW-1:0]     tbl_q;
  logic [COEF_W-1:0] amp_q;
  logic [3:0]        amp_cnt_q;
  logic [3:0]        size_q;
  logic [3:0]        run_q;

  // named internal events
  logic              code_bit, amp_bit, code_hit, code_abandon, amp_last;
  logic [TW-1:0]     tbl_eff;
  logic [CODE_W-1:0] cand_next;
  logic [LW-1:0]     len_next;
  len_entry_t        entry;
  logic              hit;
  logic [SYM_W-1:0]  hit_idx;
  logic [SYM_W-1:0]  hit_val;
  logic [3:0]        dec_size, dec_run;
  logic [COEF_W-1:0] amp_next, amp_coef;

  assign code_bit  = bit_valid && (phase_q == PH_CODE);
  assign amp_bit   = bit_valid && (phase_q == PH_AMP);
  assign tbl_eff   = (len_q == '0) ? TW'(tbl_sel) : tbl_q;
  assign cand_next = {cand_q[CODE_W-2:0], bit_in};
  assign len_next  = len_q + LW'(1);
  assign amp_next  = {amp_q[COEF_W-2:0], bit_in};
  assign amp_last  = (amp_cnt_q == 4'd1);

  hdc_len_table #(.N_TBL(N_TBL), .N_LEN(N_LEN)) u_len_table (
    .tbl(tbl_eff), .len(len_next), .entry(entry)
  );

  hdc_matcher u_matcher (
    .entry(entry), .cand(cand_next), .hit(hit), .idx(hit_idx)
  );

  hdc_sym_rom #(.N_TBL(N_TBL)) u_sym_rom (
    .tbl(tbl_eff), .idx(hit_idx), .value(hit_val)
  );

  hdc_amp_extend u_amp_extend (
    .bits(amp_next), .size(size_q), .coef(amp_coef)
  );

  assign code_hit     = code_bit && hit;
  assign code_abandon = code_bit && !hit && (int'(len_next) == N_LEN);
  assign dec_size     = hit_val[3:0];
  assign dec_run      = tbl_eff[0] ? hit_val[7:4] : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_CODE;
      cand_q     <= '0;
      len_q      <= '0;
      tbl_q      <= '0;
      amp_q      <= '0;
      amp_cnt_q  <= '0;
      size_q     <= '0;
      run_q      <= '0;
      step_valid <= 1'b0;
      step_idx   <= '0;
      sym_valid  <= 1'b0;
      sym_value  <= '0;
      coef_valid <= 1'b0;
      coef_run   <= '0;
      coef_size  <= '0;
      coef_value <= '0;
    end else begin
      step_valid <= 1'b0;
      sym_valid  <= 1'b0;
      coef_valid <= 1'b0;
      if (code_bit) begin
        step_valid <= 1'b1;
        step_idx   <= hit ? hit_idx : NO_MATCH;
        if (len_q == '0) tbl_q <= TW'(tbl_sel);
        if (code_hit) begin
          sym_valid <= 1'b1;
          sym_value <= hit_val;
          cand_q    <= '0;
          len_q     <= '0;
          if (dec_size == 4'd0) begin
            coef_valid <= 1'b1;
            coef_run   <= dec_run;
            coef_size  <= 4'd0;
            coef_value <= '0;
          end else begin
            phase_q   <= PH_AMP;
            amp_q     <= '0;
            amp_cnt_q <= dec_size;
            size_q    <= dec_size;
            run_q     <= dec_run;
          end
        end else if (code_abandon) begin
          cand_q <= '0;
          len_q  <= '0;
        end else begin
          cand_q <= cand_next;
          len_q  <= len_next;
        end
      end
      if (amp_bit) begin
        amp_q     <= amp_next;
        amp_cnt_q <= amp_cnt_q - 4'd1;
        if (amp_last) begin
          coef_valid <= 1'b1;
          coef_value <= amp_coef;
          coef_run   <= run_q;
          coef_size  <= size_q;
          phase_q    <= PH_CODE;
        end
      end
    end
  end

  // R2
  step_idx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> ((step_idx != NO_MATCH) == sym_valid));
  // R3
  sym_with_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> step_valid);
  // R6
  dc_run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !tbl_q[0]) |-> (coef_run == 4'd0));
  // R8
  zero_size_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_size == 4'd0) |-> (coef_value == '0));
  // R7
  nonzero_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_size != 4'd0) |-> (coef_value != '0));
  // R12
  amp_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amp_bit |=> !step_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!step_valid && !sym_valid && !coef_valid));
  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) < N_LEN);
endmodule

// File: tb/hdc_coef_decoder_tb.sv
`timescale 1ns/1ps
module hdc_coef_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tbl_sel = 2'd0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        step_valid, sym_valid, coef_valid;
  logic [7:0]  step_idx, sym_value;
  logic [3:0]  coef_run, coef_size;
  logic [15:0] coef_value;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  hdc_coef_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_sel(tbl_sel), .bit_valid(bit_valid),
    .bit_in(bit_in), .step_valid(step_valid), .step_idx(step_idx),
    .sym_valid(sym_valid), .sym_value(sym_value), .coef_valid(coef_valid),
    .coef_run(coef_run), .coef_size(coef_size), .coef_value(coef_value)
  );

  // code counts per length (index = length-1), bench copy of R4
  localparam int CNT [4][16] = '{
    '{0,1,5,1,1,1,1,1,1,0,0,0,0,0,0,0},
    '{0,2,1,3,3,2,4,1,0,0,0,0,0,0,0,2},
    '{0,3,1,1,1,1,1,1,1,1,1,0,0,0,0,0},
    '{0,2,2,0,3,4,0,0,5,0,0,0,0,0,0,0}
  };
  localparam logic [7:0] VAL_LAC [18] = '{8'h01,8'h02,8'h03,8'h00,8'h04,8'h11,8'h05,8'h12,
    8'h21,8'h31,8'h41,8'h06,8'h13,8'h51,8'h61,8'h07,8'hF0,8'hA3};
  localparam logic [7:0] VAL_CAC [16] = '{8'h00,8'h01,8'h02,8'h11,8'h03,8'h04,8'h21,8'h12,
    8'h31,8'h41,8'h05,8'h51,8'h13,8'h61,8'h22,8'h0A};

  typedef struct packed {
    logic [1:0]  t;
    logic [7:0]  k;
    logic [15:0] amp;
    logic [3:0]  run;
    logic [3:0]  size;
    logic [15:0] val;
  } vec_t;

  // worked cases: table, index, amplitude bits, expected run/size/value
  localparam vec_t VECS [13] = '{
    '{2'd0, 8'd2,  16'd3,    4'd0,  4'd2,  16'd3},
    '{2'd0, 8'd2,  16'd0,    4'd0,  4'd2,  -16'sd3},
    '{2'd0, 8'd1,  16'd0,    4'd0,  4'd1,  -16'sd1},
    '{2'd0, 8'd1,  16'd1,    4'd0,  4'd1,  16'd1},
    '{2'd0, 8'd11, 16'd0,    4'd0,  4'd11, -16'sd2047},
    '{2'd1, 8'd12, 16'd2,    4'd1,  4'd3,  -16'sd5},
    '{2'd3, 8'd15, 16'd1023, 4'd0,  4'd10, 16'd1023},
    '{2'd3, 8'd15, 16'd511,  4'd0,  4'd10, -16'sd512},
    '{2'd3, 8'd15, 16'd512,  4'd0,  4'd10, 16'd512},
    '{2'd1, 8'd17, 16'd4,    4'd10, 4'd3,  16'd4},
    '{2'd2, 8'd0,  16'd0,    4'd0,  4'd0,  16'd0},
    '{2'd1, 8'd3,  16'd0,    4'd0,  4'd0,  16'd0},
    '{2'd1, 8'd16, 16'd0,    4'd15, 4'd0,  16'd0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  function automatic int nsym(int t);
    int s = 0;
    for (int l = 0; l < 16; l++) s += CNT[t][l];
    return s;
  endfunction

  function automatic int tb_val(int t, int k);
    if (t == 1) return int'(VAL_LAC[k]);
    if (t == 3) return int'(VAL_CAC[k]);
    return k;
  endfunction

  // enumerate codes in canonical order until index k is reached
  task automatic tb_code(input int t, input int k, output int code, output int len);
    int c = 0;
    int n = 0;
    code = 0;
    len = 0;
    for (int l = 1; l <= 16; l++) begin
      for (int j = 0; j < CNT[t][l-1]; j++) begin
        if (n == k) begin
          code = c;
          len = l;
          return;
        end
        c++;
        n++;
      end
      c = c << 1;
    end
  endtask

  // ones'-complement form of the magnitude rule
  function automatic longint tb_coef(int bits, int size);
    int mask;
    if (size == 0) return 0;
    mask = (1 << size) - 1;
    if (((bits >> (size - 1)) & 1) == 1) return bits;
    return -longint'((~bits) & mask);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic decode_symbol(input int t, input int k, input int amp, input string tag,
                               input bit swap);
    int code, len, v, size, run;
    tb_code(t, k, code, len);
    v = tb_val(t, k);
    size = v & 15;
    run = (t % 2 == 1) ? (v >> 4) : 0;
    for (int i = len - 1; i >= 0; i--) begin
      tbl_sel = (swap && i != len - 1) ? 2'(~t) : 2'(t);
      send_bit(1'((code >> i) & 1));
      chk(tag, "step_valid", step_valid, 1);
      if (i != 0) begin
        chk(tag, "step_idx no-match", step_idx, 255);
        chk(tag, "sym_valid early", sym_valid, 0);
      end else begin
        chk(tag, "step_idx", step_idx, k);
        chk(tag, "sym_valid", sym_valid, 1);
        chk(tag, "sym_value", sym_value, v);
      end
    end
    tbl_sel = 2'(t);
    if (size == 0) begin
      chk(tag, "coef_valid size0 (R8)", coef_valid, 1);
      chk(tag, "coef_value size0 (R8)", $signed(coef_value), 0);
      chk(tag, "coef_run size0", coef_run, run);
    end else begin
      chk(tag, "coef_valid early", coef_valid, 0);
      for (int i = size - 1; i >= 0; i--) begin
        send_bit(1'((amp >> i) & 1));
        chk(tag, "step on amp bit (R12)", step_valid, 0);
        if (i != 0) chk(tag, "coef_valid early (R12)", coef_valid, 0);
        else begin
          chk(tag, "coef_valid (R12)", coef_valid, 1);
          chk(tag, "coef_run (R6)", coef_run, run);
          chk(tag, "coef_size (R6)", coef_size, size);
          chk(tag, "coef_value (R7)", $signed(coef_value), tb_coef(amp, size));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "step_valid", step_valid, 0);
    chk("R1", "sym_valid", sym_valid, 0);
    chk("R1", "coef_valid", coef_valid, 0);
    rst_n = 1'b1;

    // vector table (R3 R6 R7 R8)
    foreach (VECS[n]) begin
      decode_symbol(int'(VECS[n].t), int'(VECS[n].k), int'(VECS[n].amp), "R3", 1'b0);
      chk("R7", "vector coef_value", $signed(coef_value), $signed(VECS[n].val));
      chk("R6", "vector coef_run", coef_run, VECS[n].run);
      chk("R6", "vector coef_size", coef_size, VECS[n].size);
    end

    // R5: 16-bit codes cross the empty lengths 9..15
    decode_symbol(1, 16, 0, "R5", 1'b0);
    decode_symbol(1, 17, 6, "R5", 1'b0);

    // R10: sixteen ones never match, then a fresh code decodes
    tbl_sel = 2'd1;
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b1);
      chk("R10", "step_idx all-ones", step_idx, 255);
      chk("R10", "sym_valid all-ones", sym_valid, 0);
    end
    decode_symbol(1, 5, 1, "R10", 1'b0);

    // R9: selector changed after first bit is ignored for the rest of the code
    decode_symbol(1, 12, 5, "R9", 1'b1);
    decode_symbol(3, 15, 700, "R9", 1'b1);
    decode_symbol(0, 4, 9, "R9", 1'b1);

    // R11: idle cycles inside a code leave it intact (luma DC index 1 = 010)
    tbl_sel = 2'd0;
    send_bit(1'b0);
    tbl_sel = 2'd3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bit_in = ~bit_in;
      chk("R11", "step_valid idle", step_valid, 0);
      chk("R11", "coef_valid idle", coef_valid, 0);
    end
    send_bit(1'b1);
    send_bit(1'b0);
    chk("R11", "sym after idle gap", sym_value, 1);
    chk("R11", "idx after idle gap", step_idx, 1);
    send_bit(1'b1);
    chk("R11", "coef after idle gap", $signed(coef_value), 1);

    // R1: reset in the middle of a code discards the partial candidate
    tbl_sel = 2'd0;
    send_bit(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "step_valid in reset", step_valid, 0);
    rst_n = 1'b1;
    decode_symbol(0, 3, 2, "R1", 1'b0);

    // R2 R3 R4: random symbols from all four tables
    for (int n = 0; n < 150; n++) begin
      int t, k, size;
      t = int'($urandom_range(3, 0));
      k = int'($urandom_range(nsym(t) - 1, 0));
      size = tb_val(t, k) & 15;
      decode_symbol(t, k, int'($urandom) & ((1 << size) - 1), "R2/R4", 1'b0);
    end

    summary();
    $finish;
  end
endmodule